// File: doc/BRIEF.md
# Look-Ahead Autopull Output Shifter

This block is the output shift register of a programmable I/O state machine. An OUT request with a bit count removes that many bits from a 32-bit shift register and presents them, right-aligned, on a pin-data output for one cycle. A running shift count records how many bits have been consumed since the last refill. When autopull is enabled and the count reaches a programmable threshold, the register is reloaded with a full word from a transmit FIFO and the count returns to zero.

The refill is predicted rather than reacted to. In the cycle that accepts an OUT, the control computes the count as it will stand after that OUT. If that count meets the threshold and the FIFO holds a word, the FIFO is popped in the same cycle. The shifted-out bits and the new word are then written on the same clock edge. The next OUT can therefore issue straight away, and a refill adds no clock cycle to the instruction stream. If no word is waiting when a refill is due, a stall output holds further OUTs until one arrives.

Top module: `osr_autopull`

## Requirements
- R1: With `cfgShiftRight`=1, an OUT of N bits (`outCount` 1..31, code 0 meaning 32) takes the N least significant bits of the register. It drives them right-aligned on `pinData`, with zeros above them, with `pinValid` high in the cycle after the request is accepted.
- R2: With `cfgShiftRight`=0, an OUT of N bits takes the N most significant bits of the register. It drives them right-aligned on `pinData`, and the register shifts left by N.
- R3: Reset leaves the shift count at 32 (register treated as empty). Each accepted OUT adds N to the count, and the count saturates at 32.
- R4: When autopull is on, an accepted OUT whose post-shift count is at least the threshold, with the FIFO not empty, asserts `fifoPop` in that same cycle. The full FIFO word is loaded and the count becomes 0.
- R5: OUTs issued on consecutive cycles across a refill boundary complete on consecutive cycles. `stall` stays low, so the spacing equals that of OUTs that need no refill.
- R6: `cfgThreshold` is 5 bits wide, values 1..31 are taken literally, and code 0 means 32.
- R7: When autopull is on and the count is at or above the threshold, `stall` is high and no OUT is accepted. `pinData` and the register stay unchanged until a word is popped.
- R8: When autopull is on and the count is at or above the threshold, a refill pops the FIFO in the first cycle it is not empty. `stall` drops in the next cycle.
- R9: With autopull off, `fifoPop` and `stall` stay low whatever the count.
- R10: After reset, `pinValid` is low and `fifoPop` stays low while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoData | input | 32 | Word at the head of the transmit FIFO |
| fifoEmpty | input | 1 | FIFO holds no word |
| fifoPop | output | 1 | Consume the head word this cycle |
| outReq | input | 1 | OUT request |
| outCount | input | 5 | Bits to shift out, 0 means 32 |
| cfgThreshold | input | 5 | Autopull threshold, 0 means 32 |
| cfgShiftRight | input | 1 | 1: shift right (LSBs first), 0: shift left (MSBs first) |
| cfgAutopull | input | 1 | Enable automatic refill |
| pinData | output | 32 | Bits shifted out by the last OUT, right-aligned |
| pinValid | output | 1 | `pinData` updated this cycle |
| stall | output | 1 | Refill pending, OUT requests are held |

## Verification
A table of back-to-back OUTs is run over six FIFO words. It uses equal 8-bit steps, two 16-bit halves, a full 32-bit shift, and small odd counts, in both directions and with thresholds of 8 and of 32 (code 0). Correct data on every cycle with no stall tells the look-ahead refill apart from a refill that takes a cycle. The expected pop flag on each row tells a threshold of 32 apart from a literal 0. Directed cases then drain the FIFO to force a stall and hold, and turn autopull off to show saturation and that no pop occurs. They turn autopull back on to show the saturated count triggering an immediate refill.

// File: rtl/osr_pkg.sv
package osr_pkg;

  // Strobes from the control to the datapath, one clock cycle each.
  typedef struct packed {
    logic shiftEn;  // apply the accepted OUT to the register and pins
    logic loadEn;   // overwrite the register with the FIFO head word
  } osr_strobe_t;

endpackage

// File: rtl/osr_ctrl.sv
module osr_ctrl
  import osr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = $clog2(DATA_W),
  parameter int CNT_W  = THR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             outReq,
  input  logic [THR_W-1:0] outCount,
  input  logic [THR_W-1:0] cfgThreshold,
  input  logic             cfgAutopull,
  input  logic             fifoEmpty,
  output osr_strobe_t      strobe,
  output logic [CNT_W-1:0] shiftAmt,
  output logic             fifoPop,
  output logic             stall
);

  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);
  localparam logic [CNT_W:0]   FULL_EXT = (CNT_W+1)'(DATA_W);

  logic [CNT_W-1:0] shiftCount;
  logic [CNT_W-1:0] thrEff;
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W:0]   sumRaw;
  logic             needRefill;
  logic             accept;
  logic             lookPull;
  logic             idlePull;

  // Zero codes stand for a full word.
  always_comb begin
    thrEff   = (cfgThreshold == '0) ? FULL : CNT_W'(cfgThreshold);
    shiftAmt = (outCount == '0) ? FULL : CNT_W'(outCount);
  end

  // Look-ahead: the count as it will be once the current OUT has applied.
  always_comb begin
    sumRaw    = {1'b0, shiftCount} + {1'b0, shiftAmt};
    nextCount = (sumRaw > FULL_EXT) ? FULL : sumRaw[CNT_W-1:0];
  end

  always_comb begin
    needRefill = cfgAutopull && (shiftCount >= thrEff);
    accept     = outReq && !needRefill;
    lookPull   = accept && cfgAutopull && (nextCount >= thrEff) && !fifoEmpty;
    idlePull   = needRefill && !fifoEmpty;
    fifoPop    = lookPull || idlePull;
    stall      = needRefill;
    strobe.shiftEn = accept;
    strobe.loadEn  = fifoPop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftCount <= FULL;
    else if (fifoPop)     shiftCount <= '0;
    else if (accept)      shiftCount <= nextCount;
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    shiftCount <= FULL);

  p_pop_has_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  p_pop_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> (shiftCount == '0));

  p_autopull_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgAutopull |-> (!fifoPop && !stall));

  p_wait_holds_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stall && fifoEmpty) |=> $stable(shiftCount));

endmodule

// File: rtl/osr_datapath.sv
module osr_datapath
  import osr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  osr_strobe_t       strobe,
  input  logic [CNT_W-1:0]  shiftAmt,
  input  logic              cfgShiftRight,
  input  logic [DATA_W-1:0] fifoData,
  output logic [DATA_W-1:0] pinData,
  output logic              pinValid
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0]   shiftReg;
  logic [2*DATA_W-1:0] wideRight;
  logic [2*DATA_W-1:0] wideLeft;
  logic [DATA_W-1:0]   outBits;
  logic [DATA_W-1:0]   remainBits;

  // Double-width shifts: the half that leaves is the pin data, the other half stays.
  always_comb begin
    wideRight = {shiftReg, {DATA_W{1'b0}}} >> shiftAmt;
    wideLeft  = {{DATA_W{1'b0}}, shiftReg} << shiftAmt;
    if (cfgShiftRight) begin
      remainBits = wideRight[2*DATA_W-1:DATA_W];
      outBits    = wideRight[DATA_W-1:0] >> (FULL - shiftAmt);
    end else begin
      remainBits = wideLeft[DATA_W-1:0];
      outBits    = wideLeft[2*DATA_W-1:DATA_W];
    end
  end

  // Load wins over shift: the OUT update and the refill share one edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      pinData  <= '0;
      pinValid <= 1'b0;
    end else begin
      pinValid <= strobe.shiftEn;
      if (strobe.shiftEn) pinData <= outBits;
      if (strobe.loadEn)       shiftReg <= fifoData;
      else if (strobe.shiftEn) shiftReg <= remainBits;
    end
  end

  p_pins_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(pinData));

  p_load_takes_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> (shiftReg == $past(fifoData)));

endmodule

// File: rtl/osr_autopull.sv
module osr_autopull
  import osr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = $clog2(DATA_W),
  parameter int CNT_W  = THR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              fifoPop,
  input  logic              outReq,
  input  logic [THR_W-1:0]  outCount,
  input  logic [THR_W-1:0]  cfgThreshold,
  input  logic              cfgShiftRight,
  input  logic              cfgAutopull,
  output logic [DATA_W-1:0] pinData,
  output logic              pinValid,
  output logic              stall
);

  osr_strobe_t      strobe;
  logic [CNT_W-1:0] shiftAmt;

  osr_ctrl #(.DATA_W(DATA_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .outReq(outReq), .outCount(outCount),
    .cfgThreshold(cfgThreshold), .cfgAutopull(cfgAutopull),
    .fifoEmpty(fifoEmpty), .strobe(strobe), .shiftAmt(shiftAmt),
    .fifoPop(fifoPop), .stall(stall)
  );

  osr_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shiftAmt(shiftAmt),
    .cfgShiftRight(cfgShiftRight), .fifoData(fifoData),
    .pinData(pinData), .pinValid(pinValid)
  );

  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !pinValid);

  p_request_completes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && !stall) |=> pinValid);

endmodule

// File: tb/osr_autopull_bench.sv
module osr_autopull_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoPop, outReq, cfgShiftRight, cfgAutopull, pinValid, stall;
  logic [4:0]  outCount, cfgThreshold;
  logic [31:0] pinData, fifoData;
  logic        fifoEmpty;

  logic [31:0] fifoMem [8];
  int          wrPtr = 0;
  int          rdPtr = 0;
  int          tests = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  assign fifoEmpty = (rdPtr == wrPtr);
  assign fifoData  = fifoMem[rdPtr % 8];
  always @(posedge clk) if (fifoPop && !fifoEmpty) rdPtr <= rdPtr + 1;

  osr_autopull u_osr_autopull (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoPop(fifoPop), .outReq(outReq), .outCount(outCount),
    .cfgThreshold(cfgThreshold), .cfgShiftRight(cfgShiftRight),
    .cfgAutopull(cfgAutopull), .pinData(pinData), .pinValid(pinValid),
    .stall(stall)
  );

  typedef struct packed {
    logic [4:0]  n;
    logic        right;
    logic [4:0]  thr;
    logic        pop;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd8,  1'b1, 5'd0, 1'b0, 32'h00000021},
    '{5'd8,  1'b1, 5'd0, 1'b0, 32'h00000043},
    '{5'd8,  1'b1, 5'd0, 1'b0, 32'h00000065},
    '{5'd8,  1'b1, 5'd0, 1'b1, 32'h00000087},
    '{5'd16, 1'b1, 5'd0, 1'b0, 32'h0000F00D},
    '{5'd16, 1'b1, 5'd0, 1'b1, 32'h0000CAFE},
    '{5'd4,  1'b0, 5'd8, 1'b0, 32'h00000000},
    '{5'd4,  1'b0, 5'd8, 1'b1, 32'h0000000F},
    '{5'd12, 1'b0, 5'd8, 1'b1, 32'h00000135},
    '{5'd0,  1'b1, 5'd0, 1'b1, 32'hFFFF0000},
    '{5'd1,  1'b1, 5'd0, 1'b0, 32'h00000001},
    '{5'd3,  1'b1, 5'd0, 1'b0, 32'h00000002}
  };

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fifoMem[wrPtr % 8] = w;
    wrPtr = wrPtr + 1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    outReq = 1'b0; outCount = 5'd0; cfgThreshold = 5'd0;
    cfgShiftRight = 1'b1; cfgAutopull = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R10 / R3: empty register after reset, nothing to pop
    check(pinValid == 1'b0, "R10 pinValid", 32'(pinValid), 32'h0);
    check(fifoPop == 1'b0, "R10 fifoPop", 32'(fifoPop), 32'h0);
    check(stall == 1'b1, "R3 reset count full", 32'(stall), 32'h1);

    push(32'h87654321); push(32'hCAFEF00D); push(32'h0F1E2D3C);
    push(32'h13579BDF); push(32'hFFFF0000); push(32'hA5A5A5A5);
    #1;
    check(fifoPop == 1'b1, "R8 pop on arrival", 32'(fifoPop), 32'h1);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      outReq = 1'b1; outCount = VECS[i].n;
      cfgShiftRight = VECS[i].right; cfgThreshold = VECS[i].thr;
      #1;
      check(stall == 1'b0, "R5 no stall", 32'(stall), 32'h0);
      check(fifoPop == VECS[i].pop, "R4/R6 look-ahead pop", 32'(fifoPop), 32'(VECS[i].pop));
      @(negedge clk);
      check(pinValid == 1'b1, "R5 back-to-back completion", 32'(pinValid), 32'h1);
      check(pinData == VECS[i].exp, VECS[i].right ? "R1 right data" : "R2 left data",
            pinData, VECS[i].exp);
    end

    // R7: refill due with empty FIFO
    outCount = 5'd28; cfgShiftRight = 1'b1; cfgThreshold = 5'd0;
    #1;
    check(fifoPop == 1'b0, "R7 no pop when empty", 32'(fifoPop), 32'h0);
    @(negedge clk);
    check(pinData == 32'h0A5A5A5A, "R1 last bits", pinData, 32'h0A5A5A5A);
    check(stall == 1'b1, "R7 stall", 32'(stall), 32'h1);
    outCount = 5'd8;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(pinValid == 1'b0, "R7 OUT held", 32'(pinValid), 32'h0);
      check(pinData == 32'h0A5A5A5A, "R7 pins unchanged", pinData, 32'h0A5A5A5A);
    end
    push(32'h11223344);
    #1;
    check(fifoPop == 1'b1 && stall == 1'b1, "R8 pop in arrival cycle",
          {30'h0, fifoPop, stall}, 32'h3);
    @(negedge clk);
    check(stall == 1'b0, "R8 stall drops", 32'(stall), 32'h0);
    check(pinValid == 1'b0, "R7 no OUT during refill", 32'(pinValid), 32'h0);
    @(negedge clk);
    check(pinValid == 1'b1 && pinData == 32'h00000044, "R7 held OUT resumes",
          pinData, 32'h00000044);

    // R9: autopull off, count saturates
    push(32'hDEADBEEF);
    cfgAutopull = 1'b0; outCount = 5'd0;
    #1;
    check(fifoPop == 1'b0, "R9 no pop", 32'(fifoPop), 32'h0);
    @(negedge clk);
    check(pinData == 32'h00112233, "R1 full-word OUT", pinData, 32'h00112233);
    outCount = 5'd4;
    #1;
    check(stall == 1'b0 && fifoPop == 1'b0, "R9 no stall past full",
          {30'h0, fifoPop, stall}, 32'h0);
    @(negedge clk);
    check(pinValid == 1'b1 && pinData == 32'h0, "R9 zeros shifted", pinData, 32'h0);
    outReq = 1'b0; cfgAutopull = 1'b1;
    #1;
    check(fifoPop == 1'b1, "R3 saturated count refills", 32'(fifoPop), 32'h1);
    @(negedge clk);
    outReq = 1'b1; outCount = 5'd16;
    @(negedge clk);
    check(pinData == 32'h0000BEEF, "R1 after saturation", pinData, 32'h0000BEEF);
    outReq = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule